// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This block sits between a 32-bit datapath and a data memory that is one word wide. It handles byte, halfword and word accesses. For a store it takes the byte address, the access size and the store value. From these it produces the word address, one write strobe per byte lane, and the write word with the value steered onto the addressed lanes. For a load it takes the word returned by memory, picks out the addressed byte or halfword, and extends it to 32 bits. The extension is a sign extension or a zero extension, chosen by a signedness input.

Byte order is big-endian: the lowest address within a word occupies the most significant lane. An access whose address does not suit its size is flagged. Such an access writes nothing, and its load result is forced to zero. The block is purely combinational. The address adder, any caching and the trap taken on a misaligned access belong to the surrounding pipeline.

Top module: `lsa_unit`

## Requirements
- R1: `mem_waddr_o` equals the byte address with its two low bits dropped (address bits 31:2).
- R2: Size code 2'b00 is a byte access. For a byte store at offset k (address bits 1:0), only strobe bit 3-k is set, and `mem_wdata_o` bits 8(3-k)+7 : 8(3-k) carry `st_data_i[7:0]`. Strobe bit i always covers write-data bits 8i+7 : 8i.
- R3: Size code 2'b01 is a halfword access. A halfword store at offset 0 sets strobes 4'b1100 and places `st_data_i[15:0]` on bits 31:16. At offset 2 it sets 4'b0011 and places the same value on bits 15:0.
- R4: Size codes 2'b10 and 2'b11 are word accesses. A word store at offset 0 sets strobes 4'b1111, and `mem_wdata_o` equals `st_data_i`.
- R5: `misalign_o` is 1 for a halfword access with address bit 0 set, and for a word access with address bits 1:0 not zero. It is never 1 for a byte access.
- R6: When `st_en_i` is 0 or the access is misaligned, the strobes are 4'b0000. Write-data bits outside the set strobes are always zero.
- R7: A signed byte load (`acc_unsigned_i`=0) at offset k returns `ld_word_i` bits 31-8k : 24-8k, sign-extended to 32 bits.
- R8: An unsigned byte load returns the same byte zero-extended.
- R9: A halfword load takes bits 31:16 at offset 0 and bits 15:0 at offset 2. It is sign-extended when `acc_unsigned_i` is 0 and zero-extended when it is 1.
- R10: A word load returns `ld_word_i` unchanged, whatever the value of `acc_unsigned_i`.
- R11: A misaligned load returns zero on `ld_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_addr_i | input | 32 | Byte address of the access |
| acc_size_i | input | 2 | 00 byte, 01 halfword, 10/11 word |
| acc_unsigned_i | input | 1 | 1 selects zero extension on loads |
| st_en_i | input | 1 | The access is a store |
| st_data_i | input | 32 | Store value, right-aligned |
| ld_word_i | input | 32 | Word read from memory |
| mem_waddr_o | output | 30 | Word address to memory |
| mem_wstrb_o | output | 4 | Per-lane write strobes, bit i covers bits 8i+7:8i |
| mem_wdata_o | output | 32 | Lane-steered write word |
| ld_data_o | output | 32 | Extracted and extended load value |
| misalign_o | output | 1 | Address does not suit the access size |

## Verification
The immediate assertions evaluate whenever the inputs settle. They assume only that the size code and offset are known values, so a two-state input with any value is legal. The bench sweeps every offset across all four size codes, both signedness settings and both values of the store enable. It draws the upper address bits and the data from a random source, so that every input always carries a defined value. Stores go into two byte-array memories: one written by the bench's own model, and one written through the design's strobes. The two memories are compared after each access, and loads are served from the model memory.

// File: rtl/lsa_pkg.sv
// Shared encodings and helpers for the load/store alignment unit.
// Assumes a big-endian lane order: the lowest address uses the highest lane.
package lsa_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    // Number of bytes an access of the given size touches on a word of `lanes`.
    function automatic int size_bytes(acc_size_e sz, int lanes);
        case (sz)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return lanes;
        endcase
    endfunction

    // Least significant lane index covered by an access (may be negative if misaligned).
    function automatic int low_lane(int lanes, int ofs, int nbytes);
        return lanes - ofs - nbytes;
    endfunction

endpackage

// File: rtl/lsa_align_chk.sv
// Alignment checker: flags a halfword at an odd offset or a word at any
// non-zero offset. Assumes the halfword is two lanes and the word is all lanes.
module lsa_align_chk
    import lsa_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic [OFS_W-1:0] ofs_i,
    input  acc_size_e        size_i,
    output logic             misalign_o
);

    // Decide misalignment from size and byte offset.
    always_comb begin
        case (size_i)
            SZ_BYTE: misalign_o = 1'b0;
            SZ_HALF: misalign_o = ofs_i[0];
            default: misalign_o = (ofs_i != '0);
        endcase
    end

    // Guard: byte accesses can never be misaligned.
    always_comb begin : p_chk
        if (size_i == SZ_BYTE)
            AST_BYTE_NEVER_MISALIGNED: assert (!misalign_o) else $error("byte flagged"); // R5
    end

endmodule

// File: rtl/lsa_store_lane.sv
// Store steering: builds per-lane write strobes and moves the right-aligned
// store value onto the addressed lanes. Assumes the caller gates wr_ok_i
// with store enable and alignment; lanes without a strobe drive zero.
module lsa_store_lane
    import lsa_pkg::*;
#(
    parameter int LANES = 4,
    localparam int OFS_W = $clog2(LANES),
    localparam int DW    = 8 * LANES
) (
    input  logic [OFS_W-1:0] ofs_i,
    input  acc_size_e        size_i,
    input  logic             wr_ok_i,
    input  logic [DW-1:0]    st_data_i,
    output logic [LANES-1:0] strb_o,
    output logic [DW-1:0]    wdata_o
);

    int lo_lane;
    int hi_lane;

    // Compute the lane span covered by this access.
    always_comb begin
        hi_lane = LANES - 1 - int'(ofs_i);
        lo_lane = low_lane(LANES, int'(ofs_i), size_bytes(size_i, LANES));
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [OFS_W-1:0] src;
        // Strobe and data for lane i: byte (i - lo_lane) of the store value.
        always_comb begin
            strb_o[i] = wr_ok_i && (i >= lo_lane) && (i <= hi_lane);
            src       = OFS_W'(i - lo_lane);
            wdata_o[8*i +: 8] = strb_o[i] ? st_data_i[8*src +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/lsa_load_extract.sv
// Load extraction: selects the addressed byte or halfword from the memory
// word (big-endian) and sign- or zero-extends it. Returns zero when the
// access is misaligned; a word is passed through unchanged.
module lsa_load_extract
    import lsa_pkg::*;
#(
    parameter int LANES = 4,
    localparam int OFS_W = $clog2(LANES),
    localparam int DW    = 8 * LANES,
    localparam int SH_W  = $clog2(DW)
) (
    input  logic [OFS_W-1:0] ofs_i,
    input  acc_size_e        size_i,
    input  logic             unsigned_i,
    input  logic             misalign_i,
    input  logic [DW-1:0]    ld_word_i,
    output logic [DW-1:0]    ld_data_o
);

    logic [OFS_W-1:0] lo_u;
    logic [SH_W-1:0]  sh_amt;
    logic [DW-1:0]    shifted;
    logic [7:0]       b_val;
    logic [15:0]      h_val;

    // Right-align the addressed lanes of the returned word.
    always_comb begin
        lo_u    = OFS_W'(low_lane(LANES, int'(ofs_i), size_bytes(size_i, LANES)));
        sh_amt  = {lo_u, 3'b000};
        shifted = ld_word_i >> sh_amt;
        b_val   = shifted[7:0];
        h_val   = shifted[15:0];
    end

    // Extend according to size and signedness.
    always_comb begin
        if (misalign_i) begin
            ld_data_o = '0;
        end else begin
            case (size_i)
                SZ_BYTE: ld_data_o = {{(DW-8){b_val[7] & ~unsigned_i}}, b_val};
                SZ_HALF: ld_data_o = {{(DW-16){h_val[15] & ~unsigned_i}}, h_val};
                default: ld_data_o = ld_word_i;
            endcase
        end
    end

endmodule

// File: rtl/lsa_unit.sv
// Top of the load/store alignment unit. Purely combinational: splits the
// byte address into word address and lane offset, checks alignment, steers
// store data with strobes, and extracts/extends load data.
// Assumes a word-wide memory with big-endian lane order.
module lsa_unit
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic [ADDR_W-1:0]       acc_addr_i,
    input  logic [1:0]              acc_size_i,
    input  logic                    acc_unsigned_i,
    input  logic                    st_en_i,
    input  logic [DATA_W-1:0]       st_data_i,
    input  logic [DATA_W-1:0]       ld_word_i,
    output logic [ADDR_W-OFS_W-1:0] mem_waddr_o,
    output logic [LANES-1:0]        mem_wstrb_o,
    output logic [DATA_W-1:0]       mem_wdata_o,
    output logic [DATA_W-1:0]       ld_data_o,
    output logic                    misalign_o
);

    acc_size_e        size_e;
    logic [OFS_W-1:0] ofs;
    logic             wr_ok;

    // Split the address and decode the size field.
    always_comb begin
        size_e      = acc_size_e'(acc_size_i);
        ofs         = acc_addr_i[OFS_W-1:0];
        mem_waddr_o = acc_addr_i[ADDR_W-1:OFS_W];
        wr_ok       = st_en_i && !misalign_o;
    end

    lsa_align_chk #(.OFS_W(OFS_W)) i_align (
        .ofs_i      (ofs),
        .size_i     (size_e),
        .misalign_o (misalign_o)
    );

    lsa_store_lane #(.LANES(LANES)) i_store (
        .ofs_i     (ofs),
        .size_i    (size_e),
        .wr_ok_i   (wr_ok),
        .st_data_i (st_data_i),
        .strb_o    (mem_wstrb_o),
        .wdata_o   (mem_wdata_o)
    );

    lsa_load_extract #(.LANES(LANES)) i_load (
        .ofs_i      (ofs),
        .size_i     (size_e),
        .unsigned_i (acc_unsigned_i),
        .misalign_i (misalign_o),
        .ld_word_i  (ld_word_i),
        .ld_data_o  (ld_data_o)
    );

    // Cross-checks between the alignment, store and load paths.
    always_comb begin : p_chk
        if (misalign_o)
            AST_MISALIGN_NO_WRITE: assert (mem_wstrb_o == '0) else $error("write on misalign"); // R6
        if (misalign_o)
            AST_MISALIGN_LOAD_ZERO: assert (ld_data_o == '0) else $error("load on misalign"); // R11
        if (st_en_i && !misalign_o)
            AST_STRB_WIDTH: assert ($countones(mem_wstrb_o) == size_bytes(size_e, LANES)) else $error("strobe count"); // R2
        if (st_en_i && !misalign_o && (size_e == SZ_WORD || size_e == SZ_WIDE))
            AST_WORD_FULL: assert (&mem_wstrb_o) else $error("word strobes"); // R4
        if (!misalign_o && acc_unsigned_i && size_e == SZ_BYTE)
            AST_UBYTE_UPPER_ZERO: assert (ld_data_o[DATA_W-1:8] == '0) else $error("ubyte upper"); // R8
        if (!st_en_i)
            AST_NO_STORE_NO_STRB: assert (mem_wstrb_o == '0) else $error("strobe w/o store"); // R6
    end

endmodule

// File: tb/test_lsa_unit.sv
// Bench: sweeps offsets, sizes, signedness and store enable; compares a
// byte-array model memory against one written through the design's strobes.
module test_lsa_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] acc_addr_i = '0;
    logic [1:0]  acc_size_i = '0;
    logic        acc_unsigned_i = 1'b0;
    logic        st_en_i = 1'b0;
    logic [31:0] st_data_i = '0;
    logic [31:0] ld_word_i = '0;
    logic [29:0] mem_waddr_o;
    logic [3:0]  mem_wstrb_o;
    logic [31:0] mem_wdata_o;
    logic [31:0] ld_data_o;
    logic        misalign_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] ref_mem [16];
    logic [7:0] dut_mem [16];

    always #4 clk = ~clk; // 125 MHz

    lsa_unit i_lsa_unit (
        .acc_addr_i     (acc_addr_i),
        .acc_size_i     (acc_size_i),
        .acc_unsigned_i (acc_unsigned_i),
        .st_en_i        (st_en_i),
        .st_data_i      (st_data_i),
        .ld_word_i      (ld_word_i),
        .mem_waddr_o    (mem_waddr_o),
        .mem_wstrb_o    (mem_wstrb_o),
        .mem_wdata_o    (mem_wdata_o),
        .ld_data_o      (ld_data_o),
        .misalign_o     (misalign_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h addr=%08h size=%0d uns=%0b st=%0b",
                     req, act, exp, acc_addr_i, acc_size_i, acc_unsigned_i, st_en_i);
        end
    endtask

    function automatic int nbytes(logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic string size_req(logic [1:0] sz, bit ld, bit uns);
        if (sz == 2'd0) return ld ? (uns ? "R8" : "R7") : "R2";
        if (sz == 2'd1) return ld ? "R9" : "R3";
        return ld ? "R10" : "R4";
    endfunction

    // One access: drive at negedge, check after posedge, then update memories.
    task automatic access(input logic [3:0] lo, input logic [1:0] sz, input bit uns, input bit st);
        int          n;
        int          ofs;
        int          w;
        bit          mis;
        logic [31:0] val;
        logic [31:0] exp_ld;
        logic [3:0]  exp_strb;
        logic [31:0] strb_mask;
        @(negedge clk);
        acc_addr_i     = {$urandom_range(0, 32'h0FFF_FFFF), lo};
        acc_size_i     = sz;
        acc_unsigned_i = uns;
        st_en_i        = st;
        st_data_i      = $urandom;
        w              = int'(lo[3:2]);
        ld_word_i      = {ref_mem[4*w], ref_mem[4*w+1], ref_mem[4*w+2], ref_mem[4*w+3]};
        n   = nbytes(sz);
        ofs = int'(lo[1:0]);
        mis = (n == 2 && lo[0]) || (n == 4 && lo[1:0] != 2'b00);
        exp_strb = '0;
        val = '0;
        for (int j = 0; j < n; j++) begin
            if (!mis) begin
                val = {val[23:0], ref_mem[4*w + ofs + j]};
                if (st) exp_strb[3 - (ofs + j)] = 1'b1;
            end
        end
        if (mis) exp_ld = '0;
        else if (n == 1) exp_ld = uns ? {24'h0, val[7:0]} : {{24{val[7]}}, val[7:0]};
        else if (n == 2) exp_ld = uns ? {16'h0, val[15:0]} : {{16{val[15]}}, val[15:0]};
        else exp_ld = val;
        @(posedge clk);
        #1;
        chk("R1", {2'b00, mem_waddr_o}, acc_addr_i >> 2);
        chk("R5", {31'h0, misalign_o}, {31'h0, mis});
        chk((mis || !st) ? "R6" : size_req(sz, 1'b0, uns), {28'h0, mem_wstrb_o}, {28'h0, exp_strb});
        for (int i = 0; i < 4; i++) strb_mask[8*i +: 8] = {8{mem_wstrb_o[i]}};
        chk("R6", mem_wdata_o & ~strb_mask, 32'h0);
        chk(mis ? "R11" : size_req(sz, 1'b1, uns), ld_data_o, exp_ld);
        // Model write: bytes in address order, most significant byte first.
        if (st && !mis)
            for (int j = 0; j < n; j++) ref_mem[4*w + ofs + j] = st_data_i[8*(n-1-j) +: 8];
        // Write through the design's strobes: strobe bit i maps to byte offset 3-i.
        for (int i = 0; i < 4; i++)
            if (mem_wstrb_o[i]) dut_mem[4*w + 3 - i] = mem_wdata_o[8*i +: 8];
        for (int k = 0; k < 16; k++)
            chk(size_req(sz, 1'b0, uns), {24'h0, dut_mem[k]}, {24'h0, ref_mem[k]});
    endtask

    initial begin
        for (int k = 0; k < 16; k++) begin
            ref_mem[k] = 8'h80 + 8'(k * 9);
            dut_mem[k] = ref_mem[k];
        end
        repeat (3) @(posedge clk);
        #1;
        // Idle state: no store requested, so no strobes (R6).
        chk("R6", {28'h0, mem_wstrb_o}, 32'h0);
        rst_n = 1'b1;
        // Directed: word store at offset 0 places the value whole (R4).
        access(4'h4, 2'd2, 1'b0, 1'b1);
        chk("R4", mem_wdata_o, st_data_i);
        for (int rep = 0; rep < 3; rep++)
            for (int a = 0; a < 16; a++)
                for (int s = 0; s < 4; s++)
                    for (int u = 0; u < 2; u++)
                        for (int e = 0; e < 2; e++)
                            access(4'(a), 2'(s), u[0], e[0]);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule